// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer for 9-bit words whose write side and read side run on unrelated clocks. The writer pushes words on the rising edge of its clock, and the reader pops them on the rising edge of its own clock. Four active-low status outputs report the fill state. Two are plain flags, empty and full. The other two are threshold flags, almost-empty and almost-full. Each flag is produced in the clock domain that acts on it. The pointers cross between the domains in Gray code through a chain of synchroniser flops. For this reason a flag may clear a few cycles late, but it never sets late.

The second write-enable input has two roles, and its level while reset is held picks the role. If it is held high, it works as a second, active-high write enable. If it is held low, the block enters threshold-programming mode. In that mode the pin becomes a load strobe. While the strobe is low, write cycles store the input word into the two threshold registers, and read cycles return those registers on the output instead of FIFO data. The registers are accessed in turn: almost-empty, then almost-full, then almost-empty again. An output-enable input lets the data outputs share a bus.

Top module: `dualclk_flag_fifo`

## Requirements
- R1: While rst_n is low both pointers return to zero, so empty_n reads 0 and full_n reads 1. Both threshold registers return to OFS_DEFAULT, and both access selectors return to the almost-empty register.
- R2: A word is stored on a rising wr_clk edge only when wen_a_n is 0, wen_b_ld is 1 and full_n is 1. Any other combination leaves the FIFO contents and the write pointer unchanged.
- R3: A word is removed on a rising rd_clk edge only when ren_a_n and ren_b_n are both 0, empty_n is 1 and no threshold readback is under way. The removed word appears on dout after that edge, and words leave in the order they were written.
- R4: full_n is 0 exactly when the write side sees DEPTH stored words. A write attempted while full_n is 0 is dropped, and the previous DEPTH words are read back unchanged.
- R5: A read attempted while empty_n is 0 is ignored. dout keeps its last value, and the next word written is the next word read.
- R6: aempty_n is 0 exactly when the read side's word count is less than or equal to the almost-empty threshold.
- R7: afull_n is 0 exactly when the write side's word count plus the almost-full threshold is at least DEPTH.
- R8: The level of wen_b_ld is sampled on every clock edge while rst_n is low, and the last sample is kept. A 1 selects second-enable mode. A 0 selects threshold-programming mode, in which data is still written only when wen_b_ld is 1.
- R9: In threshold-programming mode, each wr_clk edge with wen_a_n at 0 and wen_b_ld at 0 writes din into one threshold register, almost-empty first and then almost-full, alternating. No data is written into the FIFO.
- R10: In threshold-programming mode, each rd_clk edge with both read enables at 0 and wen_b_ld at 0 loads one threshold register onto dout, almost-empty first and then almost-full, alternating. The read pointer does not move.
- R11: When oe_n is 1, dout is high impedance. When oe_n is 0, dout drives the held output word, and that word is not altered by oe_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Master reset, active low, affects both domains |
| din | input | 9 | Write data, or the threshold value during a load |
| wen_a_n | input | 1 | Primary write enable, active low |
| wen_b_ld | input | 1 | Second write enable (active high) or threshold load strobe (active low); role chosen at reset |
| ren_a_n | input | 1 | First read enable, active low |
| ren_b_n | input | 1 | Second read enable, active low |
| oe_n | input | 1 | Output enable, active low; high releases dout |
| dout | output | 9 | Read data or threshold readback, three-state |
| empty_n | output | 1 | Empty flag, active low, read clock domain |
| aempty_n | output | 1 | Almost-empty flag, active low, read clock domain |
| full_n | output | 1 | Full flag, active low, write clock domain |
| afull_n | output | 1 | Almost-full flag, active low, write clock domain |

## Verification
The properties assume two things. First, rst_n stays low for at least one edge of each clock, so that both copies of the mode bit are loaded. Second, wen_b_ld, which is also observed by the read domain, changes only while no read is in progress. To satisfy both, the stimulus holds reset for several edges of both clocks and changes wen_b_ld only on a write-clock falling edge while both read enables are high. Threshold registers are loaded only while the FIFO is empty. Every flag is sampled after enough edges of both clocks for the synchronisers to settle.

// File: rtl/dualclk_flag_fifo_pkg.sv
package dualclk_flag_fifo_pkg;

   // which threshold register the next load or readback touches
   typedef enum logic {
      SEL_AEMPTY = 1'b0,
      SEL_AFULL  = 1'b1
   } ofs_sel_e;

   function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
      return b ^ (b >> 1);
   endfunction

   // prefix xor from the top bit downwards
   function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
      logic [31:0] b;
      b = g;
      for (int s = 1; s < 32; s = s * 2) b = b ^ (b >> s);
      return b;
   endfunction

   function automatic ofs_sel_e next_sel(input ofs_sel_e s);
      return (s == SEL_AEMPTY) ? SEL_AFULL : SEL_AEMPTY;
   endfunction

endpackage

// File: rtl/dualclk_flag_fifo_sync.sv
module dualclk_flag_fifo_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("synchroniser needs at least two stages");
   end

   logic [W-1:0] stage [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage[g] <= '0;
            else        stage[g] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage[g] <= '0;
            else        stage[g] <= stage[g-1];
         end
      end
   end

   assign q = stage[STAGES-1];
endmodule

// File: rtl/dualclk_flag_fifo_ram.sv
module dualclk_flag_fifo_ram #(
   parameter int DW    = 9,
   parameter int DEPTH = 1024,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          wr_clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] cells [DEPTH];

   always_ff @(posedge wr_clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];
endmodule

// File: rtl/dualclk_flag_fifo_wr.sv
module dualclk_flag_fifo_wr
   import dualclk_flag_fifo_pkg::*;
#(
   parameter int DW          = 9,
   parameter int DEPTH       = 1024,
   parameter int OW          = 9,
   parameter int OFS_DEFAULT = 127,
   parameter int SYNC_STAGES = 2,
   localparam int AW         = $clog2(DEPTH),
   localparam int PW         = AW + 1
) (
   input  logic          wr_clk,
   input  logic          rst_n,
   input  logic          wen_a_n,
   input  logic          wen_b_ld,
   input  logic [DW-1:0] din,
   input  logic [PW-1:0] rd_gray,
   output logic [PW-1:0] wr_gray,
   output logic [PW-1:0] wr_bin,
   output logic          mem_we,
   output logic          prog_mode,
   output logic          full_n,
   output logic          afull_n,
   output logic [OW-1:0] ae_ofs,
   output logic [OW-1:0] af_ofs
);
   localparam int CW = ((PW > OW) ? PW : OW) + 1;

   logic [PW-1:0] rd_gray_s;
   logic [PW-1:0] rd_bin_s;
   logic [PW-1:0] fill;
   logic [PW-1:0] wr_bin_nx;
   logic          data_wr;
   logic          ofs_wr;
   ofs_sel_e      sel;

   dualclk_flag_fifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_rsync (
      .clk   (wr_clk),
      .rst_n (rst_n),
      .d     (rd_gray),
      .q     (rd_gray_s)
   );

   assign rd_bin_s  = PW'(gray_to_bin(32'(rd_gray_s)));
   assign fill      = wr_bin - rd_bin_s;
   assign full_n    = (fill != PW'(DEPTH));
   assign afull_n   = ((CW'(fill) + CW'(af_ofs)) < CW'(DEPTH));
   assign wr_bin_nx = wr_bin + 1'b1;

   // role of the second enable is captured while reset is held
   always_ff @(posedge wr_clk) begin
      if (!rst_n) prog_mode <= ~wen_b_ld;
   end

   assign data_wr = !wen_a_n && wen_b_ld && full_n;
   assign ofs_wr  = prog_mode && !wen_a_n && !wen_b_ld;
   assign mem_we  = data_wr;

   always_ff @(posedge wr_clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_bin  <= '0;
         wr_gray <= '0;
      end else if (data_wr) begin
         wr_bin  <= wr_bin_nx;
         wr_gray <= PW'(bin_to_gray(32'(wr_bin_nx)));
      end
   end

   always_ff @(posedge wr_clk or negedge rst_n) begin
      if (!rst_n) begin
         ae_ofs <= OW'(OFS_DEFAULT);
         af_ofs <= OW'(OFS_DEFAULT);
         sel    <= SEL_AEMPTY;
      end else if (ofs_wr) begin
         if (sel == SEL_AEMPTY) ae_ofs <= OW'(din);
         else                   af_ofs <= OW'(din);
         sel <= next_sel(sel);
      end
   end
endmodule

// File: rtl/dualclk_flag_fifo_rd.sv
module dualclk_flag_fifo_rd
   import dualclk_flag_fifo_pkg::*;
#(
   parameter int DW          = 9,
   parameter int DEPTH       = 1024,
   parameter int OW          = 9,
   parameter int SYNC_STAGES = 2,
   localparam int AW         = $clog2(DEPTH),
   localparam int PW         = AW + 1
) (
   input  logic          rd_clk,
   input  logic          rst_n,
   input  logic          ren_a_n,
   input  logic          ren_b_n,
   input  logic          wen_b_ld,
   input  logic [PW-1:0] wr_gray,
   input  logic [DW-1:0] mem_rdata,
   input  logic [OW-1:0] ae_ofs,
   input  logic [OW-1:0] af_ofs,
   output logic [PW-1:0] rd_gray,
   output logic [PW-1:0] rd_bin,
   output logic          prog_mode,
   output logic          empty_n,
   output logic          aempty_n,
   output logic [DW-1:0] q
);
   localparam int CW = ((PW > OW) ? PW : OW) + 1;

   logic [PW-1:0] wr_gray_s;
   logic [PW-1:0] wr_bin_s;
   logic [PW-1:0] fill;
   logic [PW-1:0] rd_bin_nx;
   logic          ld_now;
   logic          rd_req;
   logic          data_rd;
   logic          ofs_rd;
   ofs_sel_e      sel;

   dualclk_flag_fifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wsync (
      .clk   (rd_clk),
      .rst_n (rst_n),
      .d     (wr_gray),
      .q     (wr_gray_s)
   );

   assign wr_bin_s  = PW'(gray_to_bin(32'(wr_gray_s)));
   assign fill      = wr_bin_s - rd_bin;
   assign empty_n   = (fill != '0);
   assign aempty_n  = (CW'(fill) > CW'(ae_ofs));
   assign rd_bin_nx = rd_bin + 1'b1;

   always_ff @(posedge rd_clk) begin
      if (!rst_n) prog_mode <= ~wen_b_ld;
   end

   assign ld_now  = prog_mode && !wen_b_ld;
   assign rd_req  = !ren_a_n && !ren_b_n;
   assign ofs_rd  = rd_req && ld_now;
   assign data_rd = rd_req && !ld_now && empty_n;

   always_ff @(posedge rd_clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_bin  <= '0;
         rd_gray <= '0;
      end else if (data_rd) begin
         rd_bin  <= rd_bin_nx;
         rd_gray <= PW'(bin_to_gray(32'(rd_bin_nx)));
      end
   end

   always_ff @(posedge rd_clk or negedge rst_n) begin
      if (!rst_n) begin
         q   <= '0;
         sel <= SEL_AEMPTY;
      end else if (data_rd) begin
         q <= mem_rdata;
      end else if (ofs_rd) begin
         q   <= (sel == SEL_AEMPTY) ? DW'(ae_ofs) : DW'(af_ofs);
         sel <= next_sel(sel);
      end
   end
endmodule

// File: rtl/dualclk_flag_fifo.sv
module dualclk_flag_fifo #(
   parameter int DW          = 9,
   parameter int DEPTH       = 1024,
   parameter int OW          = 9,
   parameter int OFS_DEFAULT = 127,
   parameter int SYNC_STAGES = 2
) (
   input  logic          wr_clk,
   input  logic          rd_clk,
   input  logic          rst_n,
   input  logic [DW-1:0] din,
   input  logic          wen_a_n,
   input  logic          wen_b_ld,
   input  logic          ren_a_n,
   input  logic          ren_b_n,
   input  logic          oe_n,
   output logic [DW-1:0] dout,
   output logic          empty_n,
   output logic          aempty_n,
   output logic          full_n,
   output logic          afull_n
);
   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;

   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 4");
   end
   if (PW > 31) begin : g_bad_width
      $error("DEPTH too large for the pointer helpers");
   end
   if (OW > DW || OW < 1) begin : g_bad_ow
      $error("threshold width must fit the data bus");
   end
   if (OFS_DEFAULT < 0 || OFS_DEFAULT >= (1 << OW)) begin : g_bad_default
      $error("OFS_DEFAULT does not fit the threshold width");
   end

   logic [PW-1:0] wr_gray, rd_gray;
   logic [PW-1:0] wr_ptr, rd_ptr;
   logic          mem_we;
   logic          prog_w, prog_r;
   logic [OW-1:0] ae_ofs, af_ofs;
   logic [DW-1:0] mem_rdata;
   logic [DW-1:0] q;

   dualclk_flag_fifo_wr #(
      .DW(DW), .DEPTH(DEPTH), .OW(OW),
      .OFS_DEFAULT(OFS_DEFAULT), .SYNC_STAGES(SYNC_STAGES)
   ) u_wr (
      .wr_clk    (wr_clk),
      .rst_n     (rst_n),
      .wen_a_n   (wen_a_n),
      .wen_b_ld  (wen_b_ld),
      .din       (din),
      .rd_gray   (rd_gray),
      .wr_gray   (wr_gray),
      .wr_bin    (wr_ptr),
      .mem_we    (mem_we),
      .prog_mode (prog_w),
      .full_n    (full_n),
      .afull_n   (afull_n),
      .ae_ofs    (ae_ofs),
      .af_ofs    (af_ofs)
   );

   dualclk_flag_fifo_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
      .wr_clk (wr_clk),
      .we     (mem_we),
      .waddr  (wr_ptr[AW-1:0]),
      .wdata  (din),
      .raddr  (rd_ptr[AW-1:0]),
      .rdata  (mem_rdata)
   );

   dualclk_flag_fifo_rd #(
      .DW(DW), .DEPTH(DEPTH), .OW(OW), .SYNC_STAGES(SYNC_STAGES)
   ) u_rd (
      .rd_clk    (rd_clk),
      .rst_n     (rst_n),
      .ren_a_n   (ren_a_n),
      .ren_b_n   (ren_b_n),
      .wen_b_ld  (wen_b_ld),
      .wr_gray   (wr_gray),
      .mem_rdata (mem_rdata),
      .ae_ofs    (ae_ofs),
      .af_ofs    (af_ofs),
      .rd_gray   (rd_gray),
      .rd_bin    (rd_ptr),
      .prog_mode (prog_r),
      .empty_n   (empty_n),
      .aempty_n  (aempty_n),
      .q         (q)
   );

   assign dout = oe_n ? {DW{1'bz}} : q;
endmodule

// File: rtl/dualclk_flag_fifo_chk.sv
module dualclk_flag_fifo_chk #(
   parameter int PW = 11
) (
   input logic          wr_clk,
   input logic          rd_clk,
   input logic          rst_n,
   input logic          wen_a_n,
   input logic          wen_b_ld,
   input logic          ren_a_n,
   input logic          ren_b_n,
   input logic          empty_n,
   input logic          aempty_n,
   input logic          full_n,
   input logic          afull_n,
   input logic          prog_w,
   input logic          prog_r,
   input logic [PW-1:0] wr_ptr,
   input logic [PW-1:0] rd_ptr
);
   assert_wr_gate_R2: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (wen_a_n || !wen_b_ld) |=> $stable(wr_ptr));

   assert_rd_gate_R3: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (ren_a_n || ren_b_n) |=> $stable(rd_ptr));

   assert_no_overflow_R4: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (!full_n && !wen_a_n && wen_b_ld) |=> $stable(wr_ptr));

   assert_no_underflow_R5: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (!empty_n && !ren_a_n && !ren_b_n) |=> $stable(rd_ptr));

   assert_empty_in_aempty_R6: assert property (@(posedge rd_clk) disable iff (!rst_n)
      !empty_n |-> !aempty_n);

   assert_full_in_afull_R7: assert property (@(posedge wr_clk) disable iff (!rst_n)
      !full_n |-> !afull_n);

   assert_load_no_data_R9: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (prog_w && !wen_b_ld) |=> $stable(wr_ptr));

   assert_readback_no_pop_R10: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (prog_r && !wen_b_ld && !ren_a_n && !ren_b_n) |=> $stable(rd_ptr));
endmodule

bind dualclk_flag_fifo dualclk_flag_fifo_chk #(.PW(PW)) u_chk (
   .wr_clk   (wr_clk),
   .rd_clk   (rd_clk),
   .rst_n    (rst_n),
   .wen_a_n  (wen_a_n),
   .wen_b_ld (wen_b_ld),
   .ren_a_n  (ren_a_n),
   .ren_b_n  (ren_b_n),
   .empty_n  (empty_n),
   .aempty_n (aempty_n),
   .full_n   (full_n),
   .afull_n  (afull_n),
   .prog_w   (prog_w),
   .prog_r   (prog_r),
   .wr_ptr   (wr_ptr),
   .rd_ptr   (rd_ptr)
);

// File: tb/dualclk_flag_fifo_bench.sv
module dualclk_flag_fifo_bench;
   localparam int DW    = 9;
   localparam int DEPTH = 16;
   localparam int DEF   = 4;

   logic          wr_clk = 1'b0;
   logic          rd_clk = 1'b0;
   logic          rst_n  = 1'b0;
   logic [DW-1:0] din    = '0;
   logic          wen_a_n  = 1'b1;
   logic          wen_b_ld = 1'b1;
   logic          ren_a_n  = 1'b1;
   logic          ren_b_n  = 1'b1;
   logic          oe_n     = 1'b0;
   tri1  [DW-1:0] bus;
   logic          empty_n, aempty_n, full_n, afull_n;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 wr_clk = ~wr_clk;
   always #6 rd_clk = ~rd_clk;

   dualclk_flag_fifo #(.DW(DW), .DEPTH(DEPTH), .OFS_DEFAULT(DEF)) u_dualclk_flag_fifo (
      .wr_clk, .rd_clk, .rst_n, .din, .wen_a_n, .wen_b_ld,
      .ren_a_n, .ren_b_n, .oe_n, .dout(bus),
      .empty_n, .aempty_n, .full_n, .afull_n
   );

   // op bit 9: 1 = push the word, 0 = pop and expect the word
   localparam logic [9:0] VEC [10] = '{
      {1'b1, 9'h012}, {1'b1, 9'h034}, {1'b1, 9'h156}, {1'b0, 9'h012},
      {1'b1, 9'h078}, {1'b0, 9'h034}, {1'b0, 9'h156}, {1'b1, 9'h1F0},
      {1'b0, 9'h078}, {1'b0, 9'h1F0}
   };

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic settle();
      repeat (6) @(negedge rd_clk);
      repeat (6) @(negedge wr_clk);
   endtask

   task automatic push(input logic [DW-1:0] d);
      @(negedge wr_clk);
      din = d; wen_a_n = 1'b0;
      @(negedge wr_clk);
      wen_a_n = 1'b1;
   endtask

   task automatic pop(input logic a_n, input logic b_n);
      @(negedge rd_clk);
      ren_a_n = a_n; ren_b_n = b_n;
      @(negedge rd_clk);
      ren_a_n = 1'b1; ren_b_n = 1'b1;
   endtask

   task automatic do_reset(input logic role);
      @(negedge wr_clk);
      rst_n = 1'b0; wen_b_ld = role; wen_a_n = 1'b1;
      ren_a_n = 1'b1; ren_b_n = 1'b1;
      repeat (4) @(negedge rd_clk);
      repeat (4) @(negedge wr_clk);
      rst_n = 1'b1;
      settle();
   endtask

   initial begin
      repeat (150000) @(posedge wr_clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R1 watchdog: actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      // ---- second-enable mode
      do_reset(1'b1);
      check("R1 empty_n", DW'(empty_n), 9'd0);
      check("R1 full_n", DW'(full_n), 9'd1);
      check("R6 aempty_n at zero", DW'(aempty_n), 9'd0);
      check("R7 afull_n at zero", DW'(afull_n), 9'd1);

      for (int i = 0; i < 10; i++) begin
         if (VEC[i][9]) push(VEC[i][8:0]);
         else begin
            settle();
            pop(1'b0, 1'b0);
            check("R3 vector order", bus, VEC[i][8:0]);
         end
      end

      // R2: second enable low blocks the write
      @(negedge wr_clk); wen_b_ld = 1'b0;
      push(9'h111);
      @(negedge wr_clk); wen_b_ld = 1'b1;
      settle();
      check("R2 blocked write", DW'(empty_n), 9'd0);

      push(9'h055);
      settle();
      check("R2 write accepted", DW'(empty_n), 9'd1);
      pop(1'b0, 1'b1);
      check("R3 single enable no pop", bus, 9'h1F0);
      pop(1'b0, 1'b0);
      check("R3 pop", bus, 9'h055);
      settle();
      check("R3 empty after pop", DW'(empty_n), 9'd0);

      // R5: pop on empty
      pop(1'b0, 1'b0);
      check("R5 dout held", bus, 9'h055);
      push(9'h0AA);
      settle();
      pop(1'b0, 1'b0);
      check("R5 next word", bus, 9'h0AA);

      // R6 / R7 / R4 thresholds with default offsets of 4
      for (int i = 0; i < 4; i++) push(9'h100 + 9'(i));
      settle();
      check("R6 count 4 le 4", DW'(aempty_n), 9'd0);
      push(9'h104);
      settle();
      check("R6 count 5 gt 4", DW'(aempty_n), 9'd1);
      for (int i = 5; i < 11; i++) push(9'h100 + 9'(i));
      settle();
      check("R7 count 11", DW'(afull_n), 9'd1);
      push(9'h10B);
      settle();
      check("R7 count 12", DW'(afull_n), 9'd0);
      check("R4 not yet full", DW'(full_n), 9'd1);
      for (int i = 12; i < 16; i++) push(9'h100 + 9'(i));
      settle();
      check("R4 full", DW'(full_n), 9'd0);
      push(9'h1FF);
      settle();
      for (int i = 0; i < 16; i++) begin
         pop(1'b0, 1'b0);
         check("R4 contents kept", bus, 9'h100 + 9'(i));
      end
      settle();
      check("R4 drained", DW'(empty_n), 9'd0);

      // R11 output enable
      push(9'h0A5);
      settle();
      pop(1'b0, 1'b0);
      @(negedge rd_clk); oe_n = 1'b1; #1;
      check("R11 released", bus, 9'h1FF);
      oe_n = 1'b0; #1;
      check("R11 driven", bus, 9'h0A5);

      // ---- threshold-programming mode
      do_reset(1'b0);
      check("R1 empty_n prog", DW'(empty_n), 9'd0);
      check("R1 full_n prog", DW'(full_n), 9'd1);
      pop(1'b0, 1'b0);
      check("R10 default ae", bus, 9'(DEF));
      pop(1'b0, 1'b0);
      check("R10 default af", bus, 9'(DEF));
      push(9'd2);
      push(9'd10);
      settle();
      check("R9 no data stored", DW'(empty_n), 9'd0);
      pop(1'b0, 1'b0);
      check("R10 ae loaded", bus, 9'd2);
      pop(1'b0, 1'b0);
      check("R10 af loaded", bus, 9'd10);
      pop(1'b0, 1'b0);
      check("R10 wrap to ae", bus, 9'd2);

      @(negedge wr_clk); wen_b_ld = 1'b1;
      push(9'h031); push(9'h032);
      settle();
      check("R8 data in prog mode", DW'(empty_n), 9'd1);
      check("R9 ae=2 count 2", DW'(aempty_n), 9'd0);
      push(9'h033);
      settle();
      check("R9 ae=2 count 3", DW'(aempty_n), 9'd1);
      push(9'h034); push(9'h035);
      settle();
      check("R9 af=10 count 5", DW'(afull_n), 9'd1);
      push(9'h036);
      settle();
      check("R9 af=10 count 6", DW'(afull_n), 9'd0);

      @(negedge wr_clk); wen_b_ld = 1'b0;
      pop(1'b0, 1'b0);
      check("R10 readback af", bus, 9'd10);
      @(negedge wr_clk); wen_b_ld = 1'b1;
      pop(1'b0, 1'b0);
      check("R10 pointer unmoved", bus, 9'h031);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule